// File: doc/BRIEF.md
# Strided Mirrored Window Write Address Generator

This block produces the byte address for every write into a frame memory built from fixed-length blocks. In plain FIFO mode the address simply counts upward through the whole memory and wraps. In window mode the writes fill a rectangle of blocks. The bytes of one block come first, then the next block of the row. When a row of the programmed horizontal size is complete, the next row begins one stride away from the base of the previous row. The stride is a signed block count, so a negative stride fills rows upward. A mirror bit makes each row fill right to left. The window has no fixed height: the number of rows follows from how many bytes arrive.

A write-reset pulse, taken only in a cycle where writing is enabled, sends the address back to the window start, or to zero in FIFO mode. That same cycle is the only point at which the configuration inputs are captured. Changes made at any other time wait for the next executed write reset. Alongside the address, the block drives a write strobe that tells the memory whether the current byte is really stored. In window mode the strobe is gated by a freeze bit. In FIFO mode it is gated by an external mask pin. The address advances in both cases.

Top module: `win_wr_addr_gen`

## Requirements
- R1: While `rst_n` is low, and after it is released, `wr_addr` is 0, the captured mode is FIFO (window off), and `wr_strobe` is low whenever `wr_en` is low.
- R2: A cycle with `wr_en`=1 and `wr_rst`=0 is a write step: the address advances by one position at the next clock edge. A cycle with `wr_en`=0 leaves `wr_addr` unchanged and keeps `wr_strobe` low.
- R3: In FIFO mode the n-th write step after an executed write reset uses address n modulo 2^(BLK_AW+log2 BLK_LEN). The write reset loads 0 whatever `cfg_start` holds.
- R4: `wr_addr` is block*BLK_LEN + offset. The offset counts 0 to BLK_LEN-1 across successive write steps, and the block changes only when the offset wraps.
- R5: In window mode, with mirror off, the block for row r and column c is start + r*stride + c, modulo 2^BLK_AW. A row holds `cfg_xsize` blocks, and a value of 0 means 2^XSZ_W blocks.
- R6: With `cfg_xmirror`=1 in window mode, the block for row r and column c is start + r*stride - c, so each row runs downward from its base.
- R7: `cfg_stride` is a BLK_AW-bit two's-complement value. A negative stride places each row below the previous one in the address space.
- R8: A write reset executes only in a cycle with `wr_en`=1. `wr_strobe` is low in that cycle, and the next cycle presents the start address. A `wr_rst` with `wr_en`=0 has no effect on the address.
- R9: The configuration inputs (`cfg_*`) are captured only in an executed write-reset cycle. Changing them at any other time does not alter the address sequence or the strobe.
- R10: On a write step, `wr_strobe` equals NOT `cfg_freeze` (as captured) in window mode, with `wr_mask` ignored. In FIFO mode it equals NOT `wr_mask`, with the freeze bit ignored. The address advances whether or not the strobe is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock |
| rst_n | input | 1 | Asynchronous global reset, active low |
| wr_en | input | 1 | Write cycle enable; the address moves only when this is high |
| wr_rst | input | 1 | Write reset request, executed only together with wr_en |
| wr_mask | input | 1 | Data mask for FIFO mode; suppresses the strobe |
| cfg_win_en | input | 1 | Window mode select |
| cfg_xmirror | input | 1 | Reverse column order inside each row |
| cfg_freeze | input | 1 | Suppress the strobe in window mode |
| cfg_start | input | BLK_AW | Window start block |
| cfg_xsize | input | XSZ_W | Blocks per row (0 means 2^XSZ_W) |
| cfg_stride | input | BLK_AW | Signed block distance between row bases |
| wr_addr | output | BLK_AW+log2(BLK_LEN) | Byte address of the current write |
| wr_strobe | output | 1 | Memory write qualifier for the current cycle |

## Verification
A wrong offset or column count shows at the ports as a misplaced address within one block length of the fault. A wrong row base only shows at the first row turn after the fault, which can be up to xsize*BLK_LEN writes later. For that reason every configuration is run through at least three full rows. A configuration captured at the wrong moment shows as the whole sequence following the wrong start, direction or strobe rule, starting at the first write after the event.

// File: rtl/wwag_pkg.sv
package wwag_pkg;

   // Mode flags captured on an executed write reset
   typedef struct packed {
      logic win;     // window addressing active
      logic xmir;    // reverse column order
      logic freeze;  // strobe suppression in window mode
   } wwag_mode_t;

endpackage

// File: rtl/wwag_cfg_hold.sv
module wwag_cfg_hold
   import wwag_pkg::*;
#(
   parameter int BLK_AW = 13,
   parameter int XSZ_W  = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  wwag_mode_t        mode_in,
   input  logic [XSZ_W-1:0]  xsize_in,
   input  logic [BLK_AW-1:0] stride_in,
   output wwag_mode_t        mode_q,
   output logic [XSZ_W-1:0]  size_m1_q,
   output logic [BLK_AW-1:0] stride_q
);

   localparam logic [XSZ_W-1:0] SZ_ONE = XSZ_W'(1);

   // Size is held as (size - 1); size 0 wraps to all ones = full range
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q    <= '0;
         size_m1_q <= '0;
         stride_q  <= '0;
      end else if (load) begin
         mode_q    <= mode_in;
         size_m1_q <= xsize_in - SZ_ONE;
         stride_q  <= stride_in;
      end
   end

   // R9: held configuration moves only on a load
   a_r9_cfg_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> ($stable(mode_q) && $stable(stride_q) && $stable(size_m1_q)));

endmodule

// File: rtl/wwag_pos_count.sv
module wwag_pos_count #(
   parameter int XSZ_W = 10,
   parameter int OFF_W = 6,
   localparam int OFF_WQ = (OFF_W > 0) ? OFF_W : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              step,
   input  logic              win,
   input  logic [XSZ_W-1:0]  size_m1,
   output logic [OFF_WQ-1:0] off,
   output logic              blk_carry,
   output logic              row_end
);

   localparam logic [XSZ_W-1:0] COL_ONE = XSZ_W'(1);

   logic [XSZ_W-1:0] col;
   logic             col_last;

   generate
      if (OFF_W > 0) begin : g_off
         localparam logic [OFF_W-1:0] OFF_ONE = OFF_W'(1);
         logic [OFF_W-1:0] off_r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     off_r <= '0;
            else if (load)  off_r <= '0;
            else if (step)  off_r <= off_r + OFF_ONE;
         end
         assign off       = off_r;
         assign blk_carry = step && (off_r == {OFF_W{1'b1}});
      end else begin : g_no_off
         assign off       = '0;
         assign blk_carry = step;
      end
   endgenerate

   assign col_last = (col == size_m1);
   assign row_end  = blk_carry && win && col_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  col <= '0;
      else if (load)               col <= '0;
      else if (blk_carry && win)   col <= col_last ? '0 : col + COL_ONE;
   end

   // R5: the column index stays inside the programmed row length
   a_r5_col_bound: assert property (@(posedge clk) disable iff (!rst_n)
      win |-> (col <= size_m1));

   // R4: the offset is back at zero after a load
   a_r4_off_zero: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (off == '0));

endmodule

// File: rtl/wwag_blk_walk.sv
module wwag_blk_walk #(
   parameter int BLK_AW = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [BLK_AW-1:0] load_base,
   input  logic              blk_carry,
   input  logic              row_end,
   input  logic              mirror,
   input  logic [BLK_AW-1:0] stride,
   output logic [BLK_AW-1:0] cur
);

   localparam logic [BLK_AW-1:0] BLK_ONE = BLK_AW'(1);

   logic [BLK_AW-1:0] base;
   logic [BLK_AW-1:0] next_row;

   // Two's-complement stride: modular add covers both directions
   assign next_row = base + stride;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base <= '0;
         cur  <= '0;
      end else if (load) begin
         base <= load_base;
         cur  <= load_base;
      end else if (row_end) begin
         base <= next_row;
         cur  <= next_row;
      end else if (blk_carry) begin
         cur  <= mirror ? cur - BLK_ONE : cur + BLK_ONE;
      end
   end

   // R4: the block changes only on an offset wrap or a load
   a_r4_blk_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!blk_carry && !load) |=> $stable(cur));

   // R8: a load presents the requested base next cycle
   a_r8_load_base: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (cur == $past(load_base)));

endmodule

// File: rtl/win_wr_addr_gen.sv
module win_wr_addr_gen
   import wwag_pkg::*;
#(
   parameter int BLK_AW  = 13,
   parameter int XSZ_W   = 10,
   parameter int BLK_LEN = 64,
   localparam int OFF_W  = $clog2(BLK_LEN),
   localparam int AW     = BLK_AW + OFF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_rst,
   input  logic              wr_mask,
   input  logic              cfg_win_en,
   input  logic              cfg_xmirror,
   input  logic              cfg_freeze,
   input  logic [BLK_AW-1:0] cfg_start,
   input  logic [XSZ_W-1:0]  cfg_xsize,
   input  logic [BLK_AW-1:0] cfg_stride,
   output logic [AW-1:0]     wr_addr,
   output logic              wr_strobe
);

   localparam int OFF_WQ = (OFF_W > 0) ? OFF_W : 1;
   localparam logic [AW-1:0] ADDR_ONE = AW'(1);

   // Elaboration-time parameter checks
   generate
      if (BLK_LEN < 1 || (1 << OFF_W) != BLK_LEN) begin : g_bad_len
         $error("BLK_LEN must be a power of two");
      end
      if (BLK_AW < 2) begin : g_bad_aw
         $error("BLK_AW must be at least 2");
      end
      if (XSZ_W < 1 || XSZ_W >= BLK_AW) begin : g_bad_xsz
         $error("XSZ_W must lie between 1 and BLK_AW-1");
      end
   endgenerate

   wwag_mode_t        mode_in, mode_q;
   logic [XSZ_W-1:0]  size_m1;
   logic [BLK_AW-1:0] stride_q;
   logic [BLK_AW-1:0] load_base;
   logic [BLK_AW-1:0] cur_blk;
   logic [OFF_WQ-1:0] off;
   logic              step, load, blk_carry, row_end, mirror, suppress;

   assign step      = wr_en && !wr_rst;
   assign load      = wr_en && wr_rst;
   assign mode_in   = '{win: cfg_win_en, xmir: cfg_xmirror, freeze: cfg_freeze};
   assign load_base = cfg_win_en ? cfg_start : '0;
   assign mirror    = mode_q.win && mode_q.xmir;

   wwag_cfg_hold #(.BLK_AW(BLK_AW), .XSZ_W(XSZ_W)) i_cfg (
      .clk(clk), .rst_n(rst_n), .load(load),
      .mode_in(mode_in), .xsize_in(cfg_xsize), .stride_in(cfg_stride),
      .mode_q(mode_q), .size_m1_q(size_m1), .stride_q(stride_q)
   );

   wwag_pos_count #(.XSZ_W(XSZ_W), .OFF_W(OFF_W)) i_pos (
      .clk(clk), .rst_n(rst_n), .load(load), .step(step),
      .win(mode_q.win), .size_m1(size_m1),
      .off(off), .blk_carry(blk_carry), .row_end(row_end)
   );

   wwag_blk_walk #(.BLK_AW(BLK_AW)) i_walk (
      .clk(clk), .rst_n(rst_n), .load(load), .load_base(load_base),
      .blk_carry(blk_carry), .row_end(row_end), .mirror(mirror),
      .stride(stride_q), .cur(cur_blk)
   );

   generate
      if (OFF_W > 0) begin : g_addr_off
         assign wr_addr = {cur_blk, off};
      end else begin : g_addr_blk
         assign wr_addr = cur_blk;
      end
   endgenerate

   // Freeze overrides the mask in window mode; the mask rules otherwise
   assign suppress  = mode_q.win ? mode_q.freeze : wr_mask;
   assign wr_strobe = step && !suppress;

   // R2: no enable, no movement
   a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(wr_addr));

   // R8: a reset cycle never writes
   a_r8_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      wr_rst |-> !wr_strobe);

   // R3: FIFO mode counts linearly
   a_r3_fifo_inc: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !mode_q.win) |=> (wr_addr == $past(wr_addr) + ADDR_ONE));

   // R10: the strobe only ever accompanies a write step
   a_r10_strobe_step: assert property (@(posedge clk) disable iff (!rst_n)
      wr_strobe |-> (wr_en && !wr_rst));

endmodule

// File: tb/test_win_wr_addr_gen.sv
module test_win_wr_addr_gen;

   localparam int BLK_AW = 6;
   localparam int XSZ_W  = 3;
   localparam int BLK_LEN = 2;
   localparam int AW = 7;
   localparam int NBLK = 64;
   localparam int NADDR = 128;

   logic clk = 1'b0;
   logic rst_n, wr_en, wr_rst, wr_mask;
   logic cfg_win_en, cfg_xmirror, cfg_freeze;
   logic [BLK_AW-1:0] cfg_start, cfg_stride;
   logic [XSZ_W-1:0]  cfg_xsize;
   logic [AW-1:0]     wr_addr;
   logic              wr_strobe;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   // model of the captured configuration
   int  m_st, m_sz, m_strd;
   bit  m_mir, m_win;

   always #4 clk = ~clk;

   win_wr_addr_gen #(.BLK_AW(BLK_AW), .XSZ_W(XSZ_W), .BLK_LEN(BLK_LEN)) i_win_wr_addr_gen (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_rst(wr_rst), .wr_mask(wr_mask),
      .cfg_win_en(cfg_win_en), .cfg_xmirror(cfg_xmirror), .cfg_freeze(cfg_freeze),
      .cfg_start(cfg_start), .cfg_xsize(cfg_xsize), .cfg_stride(cfg_stride),
      .wr_addr(wr_addr), .wr_strobe(wr_strobe)
   );

   task automatic check(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // drive one cycle away from the active edge, then settle
   task automatic cyc(bit en, bit rst, bit mask);
      @(negedge clk);
      wr_en = en; wr_rst = rst; wr_mask = mask;
      #1;
   endtask

   task automatic set_cfg(bit win, bit mir, bit frz, int st, int sz, int strd);
      cfg_win_en = win; cfg_xmirror = mir; cfg_freeze = frz;
      cfg_start = BLK_AW'(st); cfg_xsize = XSZ_W'(sz); cfg_stride = BLK_AW'(strd);
   endtask

   task automatic take_model(bit win, bit mir, int st, int sz, int strd);
      m_win = win; m_mir = mir; m_st = win ? st : 0; m_sz = sz; m_strd = strd;
   endtask

   function automatic int model(int n);
      int off, bi, s, row, col, blk;
      if (!m_win) return n % NADDR;
      off = n % BLK_LEN;
      bi  = n / BLK_LEN;
      s   = (m_sz == 0) ? (1 << XSZ_W) : m_sz;
      row = bi / s;
      col = bi % s;
      blk = m_st + row * m_strd + (m_mir ? -col : col);
      blk = ((blk % NBLK) + NBLK) % NBLK;
      return blk * BLK_LEN + off;
   endfunction

   task automatic pulse_reset();
      cyc(1, 1, 0);
      check("R8 reset cycle strobe", int'(wr_strobe), 0);
   endtask

   initial begin
      int sts[3]  = '{0, 5, 60};
      int szs[3]  = '{1, 3, 0};
      int strs[3] = '{12, -9, 9};
      int n;
      rst_n = 1'b0; wr_en = 0; wr_rst = 0; wr_mask = 0;
      set_cfg(1, 1, 1, 17, 3, 9);
      repeat (3) @(negedge clk);
      #1;
      check("R1 addr in reset", int'(wr_addr), 0);
      check("R1 strobe in reset", int'(wr_strobe), 0);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      check("R1 addr after reset", int'(wr_addr), 0);
      // R1: captured mode is FIFO; live window inputs not yet taken (R9)
      take_model(0, 0, 0, 0, 0);
      for (int k = 0; k < 4; k++) begin
         cyc(1, 0, 0);
         check("R1 fifo after reset addr", int'(wr_addr), model(k));
         check("R1 fifo strobe (freeze ignored)", int'(wr_strobe), 1);
      end

      // R3/R4/R10: FIFO mode with wrap, masking, start ignored
      set_cfg(0, 1, 1, 33, 2, 5);
      take_model(0, 0, 33, 2, 5);
      pulse_reset();
      for (int k = 0; k < 150; k++) begin
         bit mk = (k % 3 == 1);
         cyc(1, 0, mk);
         check("R3 fifo addr", int'(wr_addr), model(k));
         check("R10 fifo strobe = !mask", int'(wr_strobe), int'(!mk));
      end
      n = 150;
      // R2: disabled cycles hold
      for (int k = 0; k < 3; k++) begin
         cyc(0, 0, 0);
         check("R2 hold addr", int'(wr_addr), model(n));
         check("R2 hold strobe", int'(wr_strobe), 0);
      end
      // R8: reset without enable ignored
      cyc(0, 1, 0);
      check("R8 disabled reset strobe", int'(wr_strobe), 0);
      cyc(1, 0, 0);
      check("R8 disabled reset no effect", int'(wr_addr), model(n));

      // R5/R6/R7: window sweep
      foreach (sts[a]) foreach (szs[b]) foreach (strs[c]) for (int m = 0; m < 2; m++) begin
         int s = (szs[b] == 0) ? 8 : szs[b];
         string tag = (m != 0) ? "R6 mirror addr" : (strs[c] < 0) ? "R7 neg stride addr" : "R5 window addr";
         set_cfg(1, m[0], 0, sts[a], szs[b], strs[c]);
         take_model(1, m[0], sts[a], szs[b], strs[c]);
         pulse_reset();
         for (int k = 0; k < 3 * s * BLK_LEN + 1; k++) begin
            cyc(1, 0, k[0]);
            check(tag, int'(wr_addr), model(k));
            check("R10 window strobe ignores mask", int'(wr_strobe), 1);
         end
      end

      // R10: freeze in window mode suppresses strobe, address still walks
      set_cfg(1, 0, 1, 10, 2, 4);
      take_model(1, 0, 10, 2, 4);
      pulse_reset();
      for (int k = 0; k < 10; k++) begin
         cyc(1, 0, 0);
         check("R10 freeze strobe", int'(wr_strobe), 0);
         check("R10 freeze addr advances", int'(wr_addr), model(k));
      end

      // R9: configuration changes wait for the next executed reset
      set_cfg(1, 0, 0, 20, 3, 6);
      take_model(1, 0, 20, 3, 6);
      pulse_reset();
      for (int k = 0; k < 5; k++) begin
         cyc(1, 0, 0);
         check("R9 before change", int'(wr_addr), model(k));
      end
      set_cfg(0, 1, 1, 40, 1, -3);
      for (int k = 5; k < 20; k++) begin
         cyc(1, 0, 1);
         check("R9 old cfg kept addr", int'(wr_addr), model(k));
         check("R9 old cfg kept strobe", int'(wr_strobe), 1);
      end
      set_cfg(1, 1, 0, 40, 1, -3);
      take_model(1, 1, 40, 1, -3);
      pulse_reset();
      for (int k = 0; k < 8; k++) begin
         cyc(1, 0, 0);
         check("R9 new cfg applied", int'(wr_addr), model(k));
      end

      cyc(0, 0, 0);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(8 * 150000);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule